// File: doc/BRIEF.md
# Six-Channel Programmable Clock Divider Bank

This block turns one fast input clock into six independently divided output clocks. Each channel has a control word, written through a plain strobe-and-select port. The word holds the divide ratio, a starting count offset, an inversion bit, a bit that makes the channel ignore sync, a power-down bit, an output-disable bit and a 4-bit driver-mode value. The block stores the driver-mode value and presents it on a port; it does nothing else with it. Every divided output has an exact 50% duty cycle, odd ratios included.

A shared sync input sets every channel that does not ignore sync to its programmed offset, so that channels with related ratios line up edge for edge. An output-disabled channel drives nothing, but its divider keeps counting, so it stays aligned with the other channels. When every channel is powered down, the block reports deep sleep. No data flows through the block, so it has no valid/ready handshake. Configuration writes are single-cycle strobes that are always accepted, with no back-pressure.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset, every channel is powered down, `deep_sleep` is 1, and `clk_out`, `clk_oe` and `drv_mode` are all 0.
- R2: A control word written with `cfg_we` high to channel `cfg_sel` takes effect from the next rising edge. The word layout is: bits [3:0] driver mode, [13:4] ratio code, [23:14] offset, 24 invert, 25 ignore-sync, 26 power-down, 27 output-disable. A select value of 6 or 7 changes nothing.
- R3: A ratio code N from 2 to 1023 divides by N, and code 0 divides by 1024. For even N the output is high for N/2 input periods and low for N/2 input periods.
- R4: For odd N the output is high for exactly N/2 input periods. The high time starts on a falling input edge and ends on a rising input edge.
- R5: Ratio code 1 passes the input clock straight to the channel output, subject to invert and enable.
- R6: While `sync_in` is high, each channel that does not ignore sync holds its count at the offset value. Counting resumes on the first rising edge after `sync_in` falls, and that edge loads offset+1. The output is high while the count is below ceil(N/2). With the same ratio, offsets therefore shift outputs by whole input periods.
- R7: A channel with ignore-sync set keeps counting through `sync_in`.
- R8: With invert set, an enabled channel's output is the complement of its normal output.
- R9: A powered-down channel has `clk_out` and `clk_oe` at 0, and its count is held at the offset.
- R10: `deep_sleep` is 1 exactly when all six channels are powered down. All outputs are then 0.
- R11: With output-disable set, the channel's `clk_out` and `clk_oe` are 0 while its divider keeps counting. When the bit is cleared, the output resumes in step with a channel that never stopped.
- R12: `drv_mode[4c+3:4c]` shows the driver-mode bits last written to channel c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock; every divider counts on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_in | input | 1 | High holds non-ignoring dividers at their offsets |
| cfg_we | input | 1 | Control word write strobe |
| cfg_sel | input | 3 | Channel selected for the write |
| cfg_wdata | input | 28 | Control word |
| clk_out | output | 6 | Divided clock per channel |
| clk_oe | output | 6 | Output enable per channel |
| drv_mode | output | 24 | Stored driver-mode nibble per channel |
| deep_sleep | output | 1 | All channels powered down |

## Verification
The outputs are compared in both halves of every input period against a model built from the ratio, offset and invert rules. The mixes used are all even ratios, all odd ratios, divide-by-one, divide-by-1024 with a high offset, and offsets that differ between channels. This separates a duty-cycle error from a phase error, and an off-by-one at release from a wrong wrap point. Further windows run without a new sync, around an output-disable period and after a power-down. They show whether a divider kept counting or stopped. A sync pulse held for several cycles with one ignoring channel shows whether that bit is honoured.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
  localparam int MODE_W  = 4;
  localparam int RATIO_W = 10;
  localparam int PHASE_W = RATIO_W;

  typedef struct packed {
    logic               out_dis;
    logic               pwr_down;
    logic               ign_sync;
    logic               invert;
    logic [PHASE_W-1:0] offset;
    logic [RATIO_W-1:0] ratio;
    logic [MODE_W-1:0]  mode;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);

  localparam chan_cfg_t CFG_RESET = '{
    out_dis:  1'b0,
    pwr_down: 1'b1,
    ign_sync: 1'b0,
    invert:   1'b0,
    offset:   '0,
    ratio:    '0,
    mode:     '0
  };

  // Ratio code 0 stands for the largest divide value, 2**RATIO_W.
  function automatic logic [RATIO_W:0] ratio_value(input logic [RATIO_W-1:0] code);
    logic [RATIO_W:0] v;
    v = {1'b0, code};
    if (code == '0) v = {1'b1, {RATIO_W{1'b0}}};
    return v;
  endfunction
endpackage

// File: rtl/cdb_regs.sv
module cdb_regs
  import cdb_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int SEL_W  = $clog2(NUM_CH)
) (
  input  logic                    clk_in,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [SEL_W-1:0]        cfg_sel,
  input  logic [CFG_W-1:0]        cfg_wdata,
  output chan_cfg_t [NUM_CH-1:0]  cfg_q
);
  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) cfg_q[c] <= CFG_RESET;
    end else if (cfg_we) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (cfg_sel == SEL_W'(c)) cfg_q[c] <= chan_cfg_t'(cfg_wdata);
      end
    end
  end
endmodule

// File: rtl/cdb_chan_div.sv
module cdb_chan_div
  import cdb_pkg::*;
#(
  parameter int CNT_W = RATIO_W
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [CNT_W-1:0] ratio_code,
  input  logic [CNT_W-1:0] offset,
  output logic             div_q,
  output logic             bypass
);
  localparam int NV_W = CNT_W + 1;

  logic [NV_W-1:0]  n_val;
  logic [NV_W-1:0]  half_pt;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             wrap;
  logic             rise_q;
  logic             fall_q;
  logic             odd;

  always_comb begin
    n_val   = ratio_value(ratio_code);
    half_pt = (n_val + 1'b1) >> 1;
    wrap    = ({1'b0, cnt_q} >= (n_val - 1'b1));
    odd     = n_val[0];
    bypass  = (n_val == NV_W'(1));
  end

  always_comb begin
    if (!run || hold)  cnt_d = offset;
    else if (wrap)     cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rise_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rise_q <= run & ({1'b0, cnt_d} < half_pt);
    end
  end

  // Half-period retimed copy used to trim odd-ratio high time.
  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= rise_q;
  end

  assign div_q = odd ? (rise_q & fall_q) : rise_q;
endmodule

// File: rtl/cdb_out_stage.sv
module cdb_out_stage (
  input  logic clk_in,
  input  logic div_q,
  input  logic bypass,
  input  logic invert,
  input  logic active,
  output logic pin,
  output logic oe
);
  logic src;
  always_comb begin
    src = bypass ? clk_in : div_q;
    pin = active & (src ^ invert);
    oe  = active;
  end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import cdb_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic                     clk_in,
  input  logic                     rst_n,
  input  logic                     sync_in,
  input  logic                     cfg_we,
  input  logic [2:0]               cfg_sel,
  input  logic [CFG_W-1:0]         cfg_wdata,
  output logic [NUM_CH-1:0]        clk_out,
  output logic [NUM_CH-1:0]        clk_oe,
  output logic [NUM_CH*MODE_W-1:0] drv_mode,
  output logic                     deep_sleep
);
  localparam int SEL_W = 3;

  chan_cfg_t [NUM_CH-1:0] cfg_q;
  logic [NUM_CH-1:0]      pd_vec;

  cdb_regs #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_regs (
    .clk_in    (clk_in),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg_q)
  );

  assign deep_sleep = &pd_vec;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic run;
    logic hold;
    logic div_q;
    logic bypass;

    assign pd_vec[g] = cfg_q[g].pwr_down;
    assign run       = ~cfg_q[g].pwr_down & ~deep_sleep;
    assign hold      = sync_in & ~cfg_q[g].ign_sync;
    assign drv_mode[g*MODE_W +: MODE_W] = cfg_q[g].mode;

    cdb_chan_div #(.CNT_W(RATIO_W)) u_div (
      .clk_in     (clk_in),
      .rst_n      (rst_n),
      .run        (run),
      .hold       (hold),
      .ratio_code (cfg_q[g].ratio),
      .offset     (cfg_q[g].offset),
      .div_q      (div_q),
      .bypass     (bypass)
    );

    cdb_out_stage u_out (
      .clk_in (clk_in),
      .div_q  (div_q),
      .bypass (bypass),
      .invert (cfg_q[g].invert),
      .active (run & ~cfg_q[g].out_dis),
      .pin    (clk_out[g]),
      .oe     (clk_oe[g])
    );
  end
endmodule

// File: rtl/cdb_checker.sv
module cdb_checker
  import cdb_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int SEL_W  = 3
) (
  input logic                     clk_in,
  input logic                     rst_n,
  input logic                     sync_in,
  input logic                     cfg_we,
  input logic [SEL_W-1:0]         cfg_sel,
  input logic [CFG_W-1:0]         cfg_wdata,
  input logic [NUM_CH-1:0]        clk_out,
  input logic [NUM_CH-1:0]        clk_oe,
  input logic [NUM_CH*MODE_W-1:0] drv_mode,
  input logic                     deep_sleep,
  input chan_cfg_t [NUM_CH-1:0]   cfg_q
);
  a_r10_sleep_quiet: assert property (@(posedge clk_in) disable iff (!rst_n)
    deep_sleep |-> (clk_oe == '0 && clk_out == '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    a_r9_down_silent: assert property (@(posedge clk_in) disable iff (!rst_n)
      cfg_q[g].pwr_down |-> (!clk_oe[g] && !clk_out[g]));

    a_r11_disabled_silent: assert property (@(posedge clk_in) disable iff (!rst_n)
      cfg_q[g].out_dis |-> (!clk_oe[g] && !clk_out[g]));

    a_r12_mode_latched: assert property (@(posedge clk_in) disable iff (!rst_n)
      $past(cfg_we && cfg_sel == SEL_W'(g)) |->
        drv_mode[g*MODE_W +: MODE_W] == $past(cfg_wdata[MODE_W-1:0]));

    a_r6_sync_freezes: assert property (@(posedge clk_in) disable iff (!rst_n)
      (sync_in && $past(sync_in) && $past(sync_in, 2) && !cfg_q[g].ign_sync &&
       cfg_q[g].ratio != RATIO_W'(1) &&
       cfg_q[g] == $past(cfg_q[g]) && cfg_q[g] == $past(cfg_q[g], 2))
      |-> $stable(clk_out[g]));
  end
endmodule

bind clkdiv_bank cdb_checker #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_chk (
  .clk_in     (clk_in),
  .rst_n      (rst_n),
  .sync_in    (sync_in),
  .cfg_we     (cfg_we),
  .cfg_sel    (cfg_sel),
  .cfg_wdata  (cfg_wdata),
  .clk_out    (clk_out),
  .clk_oe     (clk_oe),
  .drv_mode   (drv_mode),
  .deep_sleep (deep_sleep),
  .cfg_q      (cfg_q)
);

// File: tb/clkdiv_bank_test.sv
`timescale 1ns/100ps
module clkdiv_bank_test;
  logic        clk_in = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_in = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [27:0] cfg_wdata = '0;
  logic [5:0]  clk_out;
  logic [5:0]  clk_oe;
  logic [23:0] drv_mode;
  logic        deep_sleep;

  always #2 clk_in = ~clk_in;

  clkdiv_bank uut (
    .clk_in(clk_in), .rst_n(rst_n), .sync_in(sync_in), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .clk_out(clk_out),
    .clk_oe(clk_oe), .drv_mode(drv_mode), .deep_sleep(deep_sleep)
  );

  typedef struct {
    logic [5:0] out;
    logic [5:0] oe;
    string      tag;
  } exp_t;
  exp_t sbq[$];

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int kcount = 0;

  int m_ratio[6], m_off[6], m_mode[6];
  bit m_inv[6], m_ign[6], m_pd[6], m_dis[6];

  always @(posedge clk_in) if (!sync_in) kcount++;

  function automatic bit qv(int ch, int j);
    int n = (m_ratio[ch] == 0) ? 1024 : m_ratio[ch];
    int h = (n + 1) / 2;
    return ((m_off[ch] + j + 1) % n) < h;
  endfunction

  function automatic bit exp_bit(int ch, int k, bit hi);
    int n = (m_ratio[ch] == 0) ? 1024 : m_ratio[ch];
    bit v;
    if (m_pd[ch] || m_dis[ch]) return 1'b0;
    if (n == 1)                  v = hi;
    else if ((n % 2 == 1) && hi) v = qv(ch, k) & qv(ch, k - 1);
    else                         v = qv(ch, k);
    return v ^ m_inv[ch];
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_ch(int ch);
    @(negedge clk_in);
    cfg_we    = 1'b1;
    cfg_sel   = 3'(ch);
    cfg_wdata = {m_dis[ch], m_pd[ch], m_ign[ch], m_inv[ch], 10'(m_off[ch]),
                 10'(m_ratio[ch]), 4'(m_mode[ch])};
    @(negedge clk_in);
    cfg_we = 1'b0;
  endtask

  task automatic push_window(int ncyc, string tag);
    for (int c = 0; c < ncyc; c++) begin
      exp_t hi_e, lo_e;
      for (int ch = 0; ch < 6; ch++) begin
        hi_e.out[ch] = exp_bit(ch, kcount + c, 1'b1);
        lo_e.out[ch] = exp_bit(ch, kcount + c, 1'b0);
        hi_e.oe[ch]  = !(m_pd[ch] || m_dis[ch]);
        lo_e.oe[ch]  = hi_e.oe[ch];
      end
      hi_e.tag = tag;
      lo_e.tag = tag;
      sbq.push_back(hi_e);
      sbq.push_back(lo_e);
    end
  endtask

  task automatic sync_window(int hold, int ncyc, string tag);
    @(negedge clk_in);
    sync_in = 1'b1;
    repeat (hold) @(negedge clk_in);
    sync_in = 1'b0;
    kcount  = 0;
    #1.5;
    push_window(ncyc, tag);
    wait (sbq.size() == 0);
  endtask

  task automatic free_window(int ncyc, string tag);
    @(negedge clk_in);
    #1.5;
    push_window(ncyc, tag);
    wait (sbq.size() == 0);
  endtask

  // Monitor: compare one expected item in each half period.
  initial begin
    forever begin
      @(clk_in);
      #1;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        checks++;
        if (clk_out !== e.out || clk_oe !== e.oe) begin
          errors++;
          $display("FAIL %s out=%b oe=%b expected out=%b oe=%b",
                   e.tag, clk_out, clk_oe, e.out, e.oe);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 6; c++) begin
      m_ratio[c] = 0; m_off[c] = 0; m_mode[c] = 0;
      m_inv[c] = 0; m_ign[c] = 0; m_pd[c] = 1; m_dis[c] = 0;
    end
    repeat (3) @(negedge clk_in);
    rst_n = 1'b1;
    @(posedge clk_in); #1;
    // R1: reset state
    chk("R1 deep_sleep", deep_sleep, 1);
    chk("R1 clk_oe", clk_oe, 0);
    chk("R1 clk_out", clk_out, 0);
    chk("R1 drv_mode", drv_mode, 0);

    // R3 R4 R5 R6 R8: mixed ratios and offsets
    m_ratio[0] = 2;  m_off[0] = 0;    m_mode[0] = 3;
    m_ratio[1] = 3;  m_off[1] = 0;    m_mode[1] = 5;
    m_ratio[2] = 4;  m_off[2] = 1;    m_mode[2] = 9;  m_inv[2] = 1;
    m_ratio[3] = 5;  m_off[3] = 2;    m_mode[3] = 12;
    m_ratio[4] = 1;  m_off[4] = 0;    m_mode[4] = 6;
    m_ratio[5] = 0;  m_off[5] = 1020; m_mode[5] = 15;
    for (int c = 0; c < 6; c++) begin
      m_pd[c] = 0;
      write_ch(c);
    end
    @(posedge clk_in); #1;
    chk("R10 deep_sleep low when channels run", deep_sleep, 0);
    chk("R12 drv_mode", drv_mode,
        {4'(m_mode[5]), 4'(m_mode[4]), 4'(m_mode[3]), 4'(m_mode[2]),
         4'(m_mode[1]), 4'(m_mode[0])});
    sync_window(3, 24, "R3/R4/R5/R6/R8 mixed ratios");

    // R2: write to an unused select changes nothing
    @(negedge clk_in);
    cfg_we = 1'b1; cfg_sel = 3'd7; cfg_wdata = 28'h4000000;
    @(negedge clk_in);
    cfg_we = 1'b0;
    @(posedge clk_in); #1;
    chk("R2 unused select drv_mode", drv_mode,
        {4'(m_mode[5]), 4'(m_mode[4]), 4'(m_mode[3]), 4'(m_mode[2]),
         4'(m_mode[1]), 4'(m_mode[0])});
    chk("R2 unused select deep_sleep", deep_sleep, 0);

    // R11: disable ch3 output, divider keeps running
    m_dis[3] = 1;
    write_ch(3);
    free_window(10, "R11 disabled channel");
    m_dis[3] = 0;
    write_ch(3);
    free_window(12, "R11 realigned after enable");

    // R7: ignore-sync on ch0 while ch1 freezes
    m_ign[0] = 1;
    write_ch(0);
    begin
      bit s0[6], s1[6];
      int ch0_changes = 0, ch1_changes = 0;
      @(negedge clk_in);
      sync_in = 1'b1;
      for (int i = 0; i < 6; i++) begin
        @(posedge clk_in); #1;
        s0[i] = clk_out[0];
        s1[i] = clk_out[1];
      end
      for (int i = 1; i < 6; i++) if (s0[i] != s0[i-1]) ch0_changes++;
      for (int i = 3; i < 6; i++) if (s1[i] != s1[i-1]) ch1_changes++;
      chk("R7 ignoring channel toggles during sync", ch0_changes, 5);
      chk("R6 held channel frozen during sync", ch1_changes, 0);
      @(negedge clk_in);
      sync_in = 1'b0;
    end
    m_ign[0] = 0;
    write_ch(0);

    // R3 R4 R5 R8: odd-heavy ratios, inverted pass-through
    m_ratio[1] = 7; m_off[1] = 3;
    m_ratio[2] = 6; m_inv[2] = 0;
    m_ratio[3] = 9; m_off[3] = 0;
    m_inv[4] = 1;
    m_ratio[0] = 11; m_off[0] = 5;
    for (int c = 0; c < 5; c++) write_ch(c);
    sync_window(2, 30, "R3/R4/R5/R8 odd ratios");

    // R9: power down ch2
    m_pd[2] = 1;
    write_ch(2);
    @(posedge clk_in); #1;
    chk("R9 deep_sleep with one channel down", deep_sleep, 0);
    sync_window(2, 16, "R9 one channel down");

    // R10: everything down
    for (int c = 0; c < 6; c++) begin
      m_pd[c] = 1;
      write_ch(c);
    end
    @(posedge clk_in); #1;
    chk("R10 deep_sleep", deep_sleep, 1);
    chk("R10 clk_out high phase", clk_out, 0);
    chk("R10 clk_oe", clk_oe, 0);
    @(negedge clk_in); #1;
    chk("R10 clk_out low phase", clk_out, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule